// File: doc/BRIEF.md
# Receive FIFO with Hysteresis Flow Control

This block buffers received characters between a serial receiver, which pushes one character per cycle, and a host or DMA reader, which pops them. It soaks up bursts when the reader falls behind. It also drives the request-to-send line from the fill level, so the remote transmitter is throttled before the buffer overflows.

Two programmable watermarks give the flow control its hysteresis. When the fill count climbs to the high watermark, the line goes high and the peer is told to stop. When the count drains to the low watermark, the line goes low and the peer is allowed to send again. Between the two watermarks the line keeps its last value.

An enable input selects between watermark-driven control and a plain software-supplied level. A sticky overrun flag records characters that were lost because the buffer was full. A configuration-error output reports watermarks programmed in the wrong order; while it is raised, the flow-control level is frozen.

Top module: `rx_rts_fifo`

## Requirements
- R1: After reset the fill count is 0, `empty_o` is 1, `full_o` is 0, `ovr_o` is 0, `cfg_err_o` is 0, and with `fifo_rts_en_i` high `rts_o` is 0. The watermarks reset to low 4 and high 12.
- R2: Characters leave in the order they were accepted. `pop_data_o` always shows the oldest stored character.
- R3: With control enabled and no configuration error, a cycle in which the count goes from below `thr_hi` to at least `thr_hi` sets `rts_o` to 1 from the next cycle.
- R4: With control enabled and no configuration error, a cycle in which the count goes from above `thr_lo` to at most `thr_lo` sets `rts_o` to 0 from the next cycle.
- R5: A change in count that crosses no watermark leaves `rts_o` unchanged.
- R6: An accepted push and an accepted pop in the same cycle leave the count unchanged and never change `rts_o`.
- R7: While `fifo_rts_en_i` is 0, `rts_o` equals `sw_rts_i`. When control is re-enabled, `rts_o` starts at 0 whatever the count is.
- R8: A push while full is discarded. The count stays at the depth, and `ovr_o` is set and stays set until `ovr_clr_i` is pulsed. A new overrun in the same cycle as a clear wins, so the flag stays 1.
- R9: While the stored low watermark exceeds the high one, `cfg_err_o` is 1 and `rts_o` holds its value through any count change.
- R10: A pop while empty is ignored: the count stays 0 and `empty_o` stays 1.
- R11: Pulsing `cfg_wr_i` loads `cfg_lo_i` and `cfg_hi_i` into the watermark registers. They take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Receiver writes one character |
| push_data_i | input | DW | Character written |
| pop_i | input | 1 | Reader takes one character |
| pop_data_o | output | DW | Oldest stored character |
| count_o | output | CW | Fill level |
| full_o | output | 1 | Count equals depth |
| empty_o | output | 1 | Count is zero |
| cfg_wr_i | input | 1 | Load watermark registers |
| cfg_lo_i | input | CW | Low watermark value |
| cfg_hi_i | input | CW | High watermark value |
| fifo_rts_en_i | input | 1 | Watermark-driven flow control enable |
| sw_rts_i | input | 1 | Level used when control is disabled |
| rts_o | output | 1 | Flow control line, 1 means stop |
| cfg_err_o | output | 1 | Low watermark above high watermark |
| ovr_o | output | 1 | Sticky overrun flag |
| ovr_clr_i | input | 1 | Clear overrun flag |

## Verification
The hardest case to reach is the frozen line under a configuration error. The count must first be driven past a watermark so that `rts_o` is high, and only then are the watermarks reversed. The bench then drains and refills across both stored values and checks that nothing moves. A second hard case is re-enabling control with the buffer full. Here the line has to come back low even though the count sits far above the high watermark, which the bench reaches by filling to the depth and toggling the enable. A bench-side model of count, flag and line level predicts every cycle, while a scoreboard queue checks the order of popped data, including across discarded overrun pushes.

// File: rtl/rx_rts_pkg.sv
package rx_rts_pkg;
  typedef enum logic {
    RTS_GO   = 1'b0,
    RTS_HALT = 1'b1
  } rts_lvl_e;

  function automatic logic hit_up(input int unsigned prev, input int unsigned nxt,
                                  input int unsigned thr);
    return (prev < thr) && (nxt >= thr);
  endfunction

  function automatic logic hit_down(input int unsigned prev, input int unsigned nxt,
                                    input int unsigned thr);
    return (prev > thr) && (nxt <= thr);
  endfunction
endpackage

// File: rtl/rx_fifo_mem.sv
module rx_fifo_mem #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_en_i) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/rx_fill_cnt.sv
module rx_fill_cnt #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic          drop_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt_q;

  assign full_o    = (cnt_q == FULL_CNT);
  assign empty_o   = (cnt_q == '0);
  assign push_ok_o = push_i && !full_o;
  assign pop_ok_o  = pop_i && !empty_o;
  assign drop_o    = push_i && full_o;

  always_comb begin
    unique case ({push_ok_o, pop_ok_o})
      2'b10:   cnt_nxt_o = cnt_q + 1'b1;
      2'b01:   cnt_nxt_o = cnt_q - 1'b1;
      default: cnt_nxt_o = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rx_rts_hyst.sv
module rx_rts_hyst
  import rx_rts_pkg::*;
#(
  parameter int unsigned CW     = 5,
  parameter int unsigned LO_RST = 4,
  parameter int unsigned HI_RST = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_wr_i,
  input  logic [CW-1:0] cfg_lo_i,
  input  logic [CW-1:0] cfg_hi_i,
  input  logic          en_i,
  input  logic          sw_rts_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cnt_nxt_i,
  output logic          rts_o,
  output logic          cfg_err_o,
  output logic [CW-1:0] thr_lo_o,
  output logic [CW-1:0] thr_hi_o
);
  logic [CW-1:0] lo_q, hi_q;
  rts_lvl_e      lvl_q;
  logic          up_hit, dn_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= CW'(LO_RST);
      hi_q <= CW'(HI_RST);
    end else if (cfg_wr_i) begin
      lo_q <= cfg_lo_i;
      hi_q <= cfg_hi_i;
    end
  end

  assign cfg_err_o = (lo_q > hi_q);
  assign up_hit    = hit_up(32'(cnt_i), 32'(cnt_nxt_i), 32'(hi_q));
  assign dn_hit    = hit_down(32'(cnt_i), 32'(cnt_nxt_i), 32'(lo_q));

  // disabled state parks the level at GO so enabling starts ready
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            lvl_q <= RTS_GO;
    else if (!en_i)         lvl_q <= RTS_GO;
    else if (!cfg_err_o) begin
      if (up_hit)           lvl_q <= RTS_HALT;
      else if (dn_hit)      lvl_q <= RTS_GO;
    end
  end

  assign rts_o    = en_i ? lvl_q : sw_rts_i;
  assign thr_lo_o = lo_q;
  assign thr_hi_o = hi_q;
endmodule

// File: rtl/rx_rts_fifo.sv
module rx_rts_fifo #(
  parameter int unsigned DW     = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LO_RST = 4,
  parameter int unsigned HI_RST = 12,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  input  logic          cfg_wr_i,
  input  logic [CW-1:0] cfg_lo_i,
  input  logic [CW-1:0] cfg_hi_i,
  input  logic          fifo_rts_en_i,
  input  logic          sw_rts_i,
  output logic          rts_o,
  output logic          cfg_err_o,
  output logic          ovr_o,
  input  logic          ovr_clr_i
);
  logic          push_ok, pop_ok, drop;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] thr_lo, thr_hi;
  logic          ovr_q;

  rx_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (push_ok),
    .wr_data_i(push_data_i),
    .rd_en_i  (pop_ok),
    .rd_data_o(pop_data_o)
  );

  rx_fill_cnt #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .push_ok_o(push_ok),
    .pop_ok_o (pop_ok),
    .drop_o   (drop),
    .cnt_o    (count_o),
    .cnt_nxt_o(cnt_nxt),
    .full_o   (full_o),
    .empty_o  (empty_o)
  );

  rx_rts_hyst #(.CW(CW), .LO_RST(LO_RST), .HI_RST(HI_RST)) u_hyst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_wr_i (cfg_wr_i),
    .cfg_lo_i (cfg_lo_i),
    .cfg_hi_i (cfg_hi_i),
    .en_i     (fifo_rts_en_i),
    .sw_rts_i (sw_rts_i),
    .cnt_i    (count_o),
    .cnt_nxt_i(cnt_nxt),
    .rts_o    (rts_o),
    .cfg_err_o(cfg_err_o),
    .thr_lo_o (thr_lo),
    .thr_hi_o (thr_hi)
  );

  // new overrun wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (drop)      ovr_q <= 1'b1;
    else if (ovr_clr_i) ovr_q <= 1'b0;
  end

  assign ovr_o = ovr_q;
endmodule

// File: rtl/rx_rts_fifo_chk.sv
module rx_rts_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic [CW-1:0] count_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          cfg_wr_i,
  input logic          fifo_rts_en_i,
  input logic          sw_rts_i,
  input logic          rts_o,
  input logic          cfg_err_o,
  input logic          ovr_o,
  input logic          ovr_clr_i,
  input logic [CW-1:0] thr_lo,
  input logic [CW-1:0] thr_hi
);
  // R3
  rts_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rts_en_i && !cfg_err_o && push_i && !pop_i && !full_o &&
     ({1'b0, count_o} + 1'b1 == {1'b0, thr_hi}))
    |=> (!fifo_rts_en_i || rts_o));

  // R4
  rts_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rts_en_i && !cfg_err_o && pop_i && !push_i && !empty_o &&
     ({1'b0, count_o} == {1'b0, thr_lo} + 1'b1))
    |=> (!fifo_rts_en_i || !rts_o));

  // R6
  both_ops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o && fifo_rts_en_i)
    |=> ($stable(count_o) && (!fifo_rts_en_i || $stable(rts_o))));

  // R7
  sw_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_rts_en_i |-> (rts_o == sw_rts_i));

  // R8
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i)
    |=> (ovr_o && count_o == CW'(DEPTH)));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);

  // R9
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && fifo_rts_en_i && !cfg_wr_i)
    |=> (!fifo_rts_en_i || $stable(rts_o)));

  // R10
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

bind rx_rts_fifo rx_rts_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .count_o      (count_o),
  .full_o       (full_o),
  .empty_o      (empty_o),
  .cfg_wr_i     (cfg_wr_i),
  .fifo_rts_en_i(fifo_rts_en_i),
  .sw_rts_i     (sw_rts_i),
  .rts_o        (rts_o),
  .cfg_err_o    (cfg_err_o),
  .ovr_o        (ovr_o),
  .ovr_clr_i    (ovr_clr_i),
  .thr_lo       (thr_lo),
  .thr_hi       (thr_hi)
);

// File: tb/rx_rts_fifo_tb.sv
module rx_rts_fifo_tb;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_i = 1'b0, pop_i = 1'b0;
  logic [DW-1:0] push_data_i = '0;
  logic [DW-1:0] pop_data_o;
  logic [CW-1:0] count_o;
  logic          full_o, empty_o;
  logic          cfg_wr_i = 1'b0;
  logic [CW-1:0] cfg_lo_i = '0, cfg_hi_i = '0;
  logic          fifo_rts_en_i = 1'b1, sw_rts_i = 1'b0;
  logic          rts_o, cfg_err_o, ovr_o;
  logic          ovr_clr_i = 1'b0;

  int checks = 0, errors = 0;
  int m_cnt = 0, m_lo = 4, m_hi = 12;
  logic m_rts = 1'b0, m_ovr = 1'b0;
  logic [DW-1:0] next_byte = 8'h10;
  logic [DW-1:0] exp_q [$];

  always #4 clk_i = ~clk_i;

  rx_rts_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (.*);

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: every accepted pop is compared with the queue head
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && pop_i && !empty_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 pop with empty scoreboard: actual %0d expected none", pop_data_o);
      end else begin
        check("R2", "pop data", int'(pop_data_o), int'(exp_q.pop_front()));
      end
    end
  end

  // called at a falling edge; drives one cycle and checks the outcome
  task automatic op(input bit p, input bit q, input bit clr, input string tag);
    bit acc_p, acc_q;
    int nc;
    push_i = p; pop_i = q; ovr_clr_i = clr; push_data_i = next_byte;
    acc_p = p && (m_cnt < DEPTH);
    acc_q = q && (m_cnt > 0);
    if (acc_p) exp_q.push_back(next_byte);
    if (p) next_byte++;
    nc = m_cnt + int'(acc_p) - int'(acc_q);
    if (p && !acc_p) m_ovr = 1'b1;
    else if (clr)    m_ovr = 1'b0;
    if (!fifo_rts_en_i) m_rts = 1'b0;
    else if (m_lo <= m_hi) begin
      if (m_cnt < m_hi && nc >= m_hi)      m_rts = 1'b1;
      else if (m_cnt > m_lo && nc <= m_lo) m_rts = 1'b0;
    end
    m_cnt = nc;
    if (cfg_wr_i) begin m_lo = int'(cfg_lo_i); m_hi = int'(cfg_hi_i); end
    @(negedge clk_i);
    push_i = 1'b0; pop_i = 1'b0; ovr_clr_i = 1'b0; cfg_wr_i = 1'b0;
    check(tag, "count", int'(count_o), m_cnt);
    check(tag, "rts", int'(rts_o), int'(fifo_rts_en_i ? m_rts : sw_rts_i));
    check(tag, "overrun", int'(ovr_o), int'(m_ovr));
    check(tag, "full", int'(full_o), int'(m_cnt == DEPTH));
    check(tag, "empty", int'(empty_o), int'(m_cnt == 0));
    check(tag, "cfg_err", int'(cfg_err_o), int'(m_lo > m_hi));
  endtask

  task automatic load_thr(input int lo, input int hi, input string tag);
    cfg_wr_i = 1'b1; cfg_lo_i = CW'(lo); cfg_hi_i = CW'(hi);
    op(0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1", "count", int'(count_o), 0);
    check("R1", "empty", int'(empty_o), 1);
    check("R1", "full", int'(full_o), 0);
    check("R1", "rts", int'(rts_o), 0);
    check("R1", "overrun", int'(ovr_o), 0);
    check("R1", "cfg_err", int'(cfg_err_o), 0);
    op(0, 0, 0, "R1");

    load_thr(3, 6, "R11");
    op(0, 1, 0, "R10");
    op(0, 1, 0, "R10");
    for (int i = 0; i < 5; i++) op(1, 0, 0, "R5");
    op(1, 0, 0, "R3");
    check("R3", "rts high at high mark", int'(rts_o), 1);
    for (int i = 0; i < 4; i++) op(1, 0, 0, "R5");
    for (int i = 0; i < 6; i++) op(0, 1, 0, "R5");
    op(0, 1, 0, "R4");
    check("R4", "rts low at low mark", int'(rts_o), 0);
    op(1, 1, 0, "R6");
    for (int i = 0; i < 13; i++) op(1, 0, 0, "R2");
    op(1, 0, 0, "R8");
    check("R8", "overrun set", int'(ovr_o), 1);
    op(0, 0, 0, "R8");
    op(0, 0, 1, "R8");
    op(1, 0, 1, "R8");
    op(0, 0, 1, "R8");

    fifo_rts_en_i = 1'b0; sw_rts_i = 1'b1;
    op(0, 0, 0, "R7");
    sw_rts_i = 1'b0;
    op(0, 0, 0, "R7");
    sw_rts_i = 1'b1;
    fifo_rts_en_i = 1'b1;
    op(0, 0, 0, "R7");
    check("R7", "rts low after enable while full", int'(rts_o), 0);

    for (int i = 0; i < 16; i++) op(0, 1, 0, "R2");
    for (int i = 0; i < 6; i++) op(1, 0, 0, "R3");
    load_thr(10, 2, "R9");
    for (int i = 0; i < 6; i++) op(0, 1, 0, "R9");
    for (int i = 0; i < 12; i++) op(1, 0, 0, "R9");
    check("R9", "rts frozen high", int'(rts_o), 1);
    load_thr(2, 8, "R11");
    for (int i = 0; i < 10; i++) op(0, 1, 0, "R4");
    check("R4", "rts low after drain", int'(rts_o), 0);
    for (int i = 0; i < 2; i++) op(0, 1, 0, "R2");
    check("R2", "scoreboard drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule